// File: doc/BRIEF.md
# Branch and Skip Sequencer

This block carries out the program-flow instructions of a small 8-bit processor that uses a 16-bit program counter. The surrounding core fetches an opcode. In that fetch cycle it raises `start_i` and presents the opcode, the program counter (already pointing one byte past the opcode) and the live status bits. The block chooses a condition, reads any address bytes it needs through a single-byte combinational read port, and produces the next program counter.

The block supports four kinds of instruction:
- A two-byte short branch. It stays within the page that holds its address byte.
- A three-byte long branch. It can reach any address.
- A one-byte short skip. It always steps over one byte.
- A one-byte long skip. When its condition holds, it steps over two bytes without reading them.

The block pulses `done_o` in the final cycle of each instruction. It then reports how many machine cycles the instruction used. Opcodes outside these four classes are ignored.

Top module: `bsq_seq`

## Requirements
- R1: After reset, `pc_o` is 0, `cycles_o` is 0, and `done_o` and `mem_rd_o` are low.
- R2: Opcode bits 7..4 select the class: 0x3 is a short branch, 0xC is a long branch, 0xD is a long skip and 0xE is a short skip. Bit 3 inverts the condition. Bits 2..0 select the source: 0 is constant one, 1 is accumulator-zero, 2 is carry, 3 is Q, and 4..7 are external flags 0..3. A `start_i` with any other class produces no `done_o` and leaves `pc_o` unchanged.
- R3: A short branch reads one byte at the incoming PC. If the condition holds, the new PC is {incoming PC bits 15..8, that byte}. Otherwise the new PC is the incoming PC + 1. The instruction uses 2 cycles.
- R4: A long branch reads the high byte at PC and then the low byte at PC+1. If the condition holds, the new PC is {high, low}. Otherwise the new PC is PC+2. The instruction uses 3 cycles. Sources 4..7 never branch, whatever the polarity.
- R5: A short skip always gives PC+1, uses 2 cycles and performs no memory read.
- R6: A long skip gives PC+2 if the condition holds and PC otherwise. It uses 3 cycles and performs no memory read. Source 4 with bit 3 clear tests interrupt-enable = 1. Every other source from 4 to 7 never skips.
- R7: `done_o` is high for exactly one cycle, which is the last cycle of the instruction. From the next cycle on, `cycles_o` holds 2 or 3 and `pc_o` holds the new PC.
- R8: The condition is sampled in the fetch cycle. Status inputs that change during the execute cycles have no effect.
- R9: A `start_i` that arrives while an instruction is executing is ignored. This includes the cycle in which `done_o` is high.
- R10: `mem_rd_o` is high only in a cycle that reads an address byte. In that cycle `mem_rdata_i` is taken combinationally from `mem_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Fetch cycle of a new instruction |
| opcode_i | input | 8 | Fetched opcode |
| pc_i | input | 16 | PC pointing past the opcode |
| acc_zero_i | input | 1 | Accumulator is zero |
| carry_i | input | 1 | Carry flag |
| q_i | input | 1 | Output latch Q |
| ext_flag_i | input | 4 | External flag pins |
| ie_i | input | 1 | Interrupt enable |
| mem_rd_o | output | 1 | Address-byte read strobe |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, same cycle |
| done_o | output | 1 | Last cycle of the instruction |
| pc_o | output | 16 | Program counter |
| cycles_o | output | 2 | Cycles used by the last instruction |

## Verification
The first pair that can coincide is the completion of an instruction and the request for the next one. The bench raises `start_i` again in the cycle right after the fetch. For a short instruction that cycle is the `done_o` cycle. For a long one it is the first execute cycle. The scoreboard then requires that the original result appears, with no extra completion. The second pair is a condition being decided while its status input changes. Every instruction inverts all status inputs immediately after its fetch cycle, so a result that follows the late values is reported.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int OPC_W   = 8;
    localparam int NUM_EXT = 4;

    localparam logic [3:0] GRP_SBR  = 4'h3;
    localparam logic [3:0] GRP_LBR  = 4'hC;
    localparam logic [3:0] GRP_LSKP = 4'hD;
    localparam logic [3:0] GRP_SSKP = 4'hE;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_SBR,
        CLS_LBR,
        CLS_SSKP,
        CLS_LSKP
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EX1,
        ST_EX2
    } state_e;
endpackage

// File: rtl/bsq_decode.sv
module bsq_decode
    import bsq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output cls_e             cls_o,
    output logic [2:0]       src_o,
    output logic             inv_o
);
    always_comb begin
        unique case (opcode_i[7:4])
            GRP_SBR:  cls_o = CLS_SBR;
            GRP_LBR:  cls_o = CLS_LBR;
            GRP_LSKP: cls_o = CLS_LSKP;
            GRP_SSKP: cls_o = CLS_SSKP;
            default:  cls_o = CLS_NONE;
        endcase
        src_o = opcode_i[2:0];
        inv_o = opcode_i[3];
    end
endmodule

// File: rtl/bsq_cond.sv
module bsq_cond
    import bsq_pkg::*;
(
    input  cls_e               cls_i,
    input  logic [2:0]         src_i,
    input  logic               inv_i,
    input  logic               acc_zero_i,
    input  logic               carry_i,
    input  logic               q_i,
    input  logic [NUM_EXT-1:0] ext_flag_i,
    input  logic               ie_i,
    output logic               taken_o
);
    logic raw;
    logic long_form;

    always_comb begin
        unique case (src_i)
            3'd0:    raw = 1'b1;
            3'd1:    raw = acc_zero_i;
            3'd2:    raw = carry_i;
            3'd3:    raw = q_i;
            default: raw = ext_flag_i[src_i[1:0]];
        endcase
        long_form = (cls_i == CLS_LBR) || (cls_i == CLS_LSKP);
        if (long_form && src_i[2]) begin
            // long forms have no external-flag tests; one skip tests IE
            taken_o = (cls_i == CLS_LSKP) && (src_i == 3'd4) && !inv_i && ie_i;
        end else begin
            taken_o = raw ^ inv_i;
        end
    end
endmodule

// File: rtl/bsq_seq.sv
module bsq_seq
    import bsq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [OPC_W-1:0]      opcode_i,
    input  logic [2*DATA_W-1:0]   pc_i,
    input  logic                  acc_zero_i,
    input  logic                  carry_i,
    input  logic                  q_i,
    input  logic [NUM_EXT-1:0]    ext_flag_i,
    input  logic                  ie_i,
    output logic                  mem_rd_o,
    output logic [2*DATA_W-1:0]   mem_addr_o,
    input  logic [DATA_W-1:0]     mem_rdata_i,
    output logic                  done_o,
    output logic [2*DATA_W-1:0]   pc_o,
    output logic [1:0]            cycles_o
);
    localparam int PC_W  = 2 * DATA_W;
    localparam int CYC_W = 2;

    typedef struct packed {
        state_e             state;
        cls_e               cls;
        logic               taken;
        logic [PC_W-1:0]    pc;
        logic [DATA_W-1:0]  hi;
        logic [CYC_W-1:0]   cnt;
        logic [CYC_W-1:0]   cyc_last;
    } seq_t;

    seq_t s_d, s_q;

    cls_e       dec_cls;
    logic [2:0] dec_src;
    logic       dec_inv;
    logic       cond_taken;

    bsq_decode u_decode (
        .opcode_i (opcode_i),
        .cls_o    (dec_cls),
        .src_o    (dec_src),
        .inv_o    (dec_inv)
    );

    bsq_cond u_cond (
        .cls_i      (dec_cls),
        .src_i      (dec_src),
        .inv_i      (dec_inv),
        .acc_zero_i (acc_zero_i),
        .carry_i    (carry_i),
        .q_i        (q_i),
        .ext_flag_i (ext_flag_i),
        .ie_i       (ie_i),
        .taken_o    (cond_taken)
    );

    always_comb begin
        s_d        = s_q;
        done_o     = 1'b0;
        mem_rd_o   = 1'b0;
        mem_addr_o = s_q.pc;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i && dec_cls != CLS_NONE) begin
                    s_d.state = ST_EX1;
                    s_d.cls   = dec_cls;
                    s_d.taken = cond_taken;
                    s_d.pc    = pc_i;
                    s_d.cnt   = CYC_W'(1);
                end
            end
            ST_EX1: begin
                s_d.cnt = s_q.cnt + CYC_W'(1);
                unique case (s_q.cls)
                    CLS_SBR: begin
                        mem_rd_o       = 1'b1;
                        done_o         = 1'b1;
                        s_d.state      = ST_IDLE;
                        s_d.cyc_last   = s_q.cnt + CYC_W'(1);
                        s_d.pc         = s_q.taken ? {s_q.pc[PC_W-1:DATA_W], mem_rdata_i}
                                                   : s_q.pc + PC_W'(1);
                    end
                    CLS_SSKP: begin
                        done_o       = 1'b1;
                        s_d.state    = ST_IDLE;
                        s_d.cyc_last = s_q.cnt + CYC_W'(1);
                        s_d.pc       = s_q.pc + PC_W'(1);
                    end
                    CLS_LBR: begin
                        mem_rd_o  = 1'b1;
                        s_d.hi    = mem_rdata_i;
                        s_d.state = ST_EX2;
                    end
                    default: begin
                        s_d.state = ST_EX2;
                    end
                endcase
            end
            ST_EX2: begin
                done_o       = 1'b1;
                s_d.state    = ST_IDLE;
                s_d.cnt      = s_q.cnt + CYC_W'(1);
                s_d.cyc_last = s_q.cnt + CYC_W'(1);
                if (s_q.cls == CLS_LBR) begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = s_q.pc + PC_W'(1);
                    s_d.pc     = s_q.taken ? {s_q.hi, mem_rdata_i} : s_q.pc + PC_W'(2);
                end else begin
                    s_d.pc     = s_q.taken ? s_q.pc + PC_W'(2) : s_q.pc;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, cls: CLS_NONE, taken: 1'b0, pc: '0,
                     hi: '0, cnt: '0, cyc_last: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o     = s_q.pc;
    assign cycles_o = s_q.cyc_last;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_SHORT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && s_q.cls == CLS_SBR && s_q.taken)
        |=> pc_o[PC_W-1:DATA_W] == $past(pc_o[PC_W-1:DATA_W])); // R3

    AST_LONG_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && s_q.cls == CLS_LBR && !s_q.taken)
        |=> pc_o == $past(pc_o) + PC_W'(2)); // R4

    AST_SKIP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE && (s_q.cls == CLS_SSKP || s_q.cls == CLS_LSKP))
        |-> !mem_rd_o); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE) |-> (!mem_rd_o && !done_o)); // R10

    AST_LONG_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (s_q.cls == CLS_LBR || s_q.cls == CLS_LSKP))
        |=> cycles_o == CYC_W'(3)); // R7
endmodule

// File: tb/bsq_seq_tb.sv
module bsq_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [15:0] pc_i = '0;
    logic        acc_zero_i = 1'b0, carry_i = 1'b0, q_i = 1'b0, ie_i = 1'b0;
    logic [3:0]  ext_flag_i = '0;
    logic        mem_rd_o, done_o;
    logic [15:0] mem_addr_o, pc_o;
    logic [7:0]  mem_rdata_i;
    logic [1:0]  cycles_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] pc_exp;
        int          cyc_exp;
        int          start_cyc;
        string       tag;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata_i = mem_f(mem_addr_o);

    bsq_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i), .pc_i(pc_i),
        .acc_zero_i(acc_zero_i), .carry_i(carry_i), .q_i(q_i), .ext_flag_i(ext_flag_i),
        .ie_i(ie_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .pc_o(pc_o), .cycles_o(cycles_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // fl = {ie, ext[3:0], q, carry, acc_zero}
    function automatic bit exp_taken(input logic [7:0] op, input logic [7:0] fl);
        logic [2:0] src = op[2:0];
        bit inv = op[3];
        bit raw;
        case (src)
            3'd0: raw = 1;
            3'd1: raw = fl[0];
            3'd2: raw = fl[1];
            3'd3: raw = fl[2];
            default: raw = fl[3 + int'(src) - 4];
        endcase
        if (op[7:4] == 4'hC && src >= 3'd4) return 0;
        if (op[7:4] == 4'hD && src >= 3'd4) return (src == 3'd4 && !inv) ? fl[7] : 1'b0;
        return raw ^ inv;
    endfunction

    task automatic run(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] fl,
                       input bit poke, input string tag);
        item_t it;
        bit t = exp_taken(op, fl);
        case (op[7:4])
            4'h3: begin it.cyc_exp = 2; it.pc_exp = t ? {pc[15:8], mem_f(pc)} : pc + 16'd1; end
            4'hC: begin it.cyc_exp = 3; it.pc_exp = t ? {mem_f(pc), mem_f(pc + 16'd1)} : pc + 16'd2; end
            4'hD: begin it.cyc_exp = 3; it.pc_exp = t ? pc + 16'd2 : pc; end
            default: begin it.cyc_exp = 2; it.pc_exp = pc + 16'd1; end
        endcase
        it.tag = tag;
        @(negedge clk);
        it.start_cyc = cyc;
        sb.push_back(it);
        start_i = 1'b1; opcode_i = op; pc_i = pc;
        {ie_i, ext_flag_i, q_i, carry_i, acc_zero_i} = fl;
        @(negedge clk);
        // R8: status flips right after the fetch cycle
        {ie_i, ext_flag_i, q_i, carry_i, acc_zero_i} = ~fl;
        if (poke) begin
            // R9: new request while busy (the done cycle for short forms)
            opcode_i = 8'h30; pc_i = ~pc;
            @(negedge clk);
        end
        start_i = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops and compares results
    initial begin : monitor
        bit pend = 0;
        item_t cur;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pend) begin
                    check(pc_o == cur.pc_exp, {cur.tag, " pc"}, pc_o, cur.pc_exp);
                    check(cycles_o == 2'(cur.cyc_exp), "R7 cycles_o", cycles_o, cur.cyc_exp);
                    void'(sb.pop_front());
                    pend = 0;
                end
                if (done_o) begin
                    done_cnt++;
                    if (sb.size() == 0) begin
                        check(0, "R9 unexpected done", 1, 0);
                    end else begin
                        cur = sb[0];
                        pend = 1;
                        check(cyc - cur.start_cyc + 1 == cur.cyc_exp, {cur.tag, " latency"},
                              cyc - cur.start_cyc + 1, cur.cyc_exp);
                    end
                end
                if (mem_rd_o && sb.size() != 0 && (sb[0].tag[1] == "5" || sb[0].tag[1] == "6"))
                    check(0, "R10 read during skip", 1, 0);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin : driver
        logic [15:0] prev;
        int dc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pc_o == 16'h0 && cycles_o == 2'd0, "R1 reset pc/cycles", pc_o, 0);
        check(!done_o && !mem_rd_o, "R1 reset strobes", {done_o, mem_rd_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 short branch
        run(8'h30, 16'h1234, 8'h00, 0, "R3 sbr always");
        run(8'h38, 16'h1234, 8'h00, 0, "R3 sbr never");
        run(8'h30, 16'h12FF, 8'h00, 0, "R3 sbr page edge taken");
        run(8'h38, 16'h12FF, 8'h00, 0, "R3 sbr page edge fail");
        run(8'h31, 16'h2000, 8'h01, 0, "R3 sbr acc zero");
        run(8'h36, 16'h2100, 8'h20, 0, "R3 sbr ext2 set");
        run(8'h3E, 16'h2200, 8'h20, 0, "R3 sbr ext2 inverted");
        run(8'h3F, 16'h2300, 8'h00, 0, "R3 sbr ext3 clear");
        // R4 long branch
        run(8'hC0, 16'h4321, 8'h00, 0, "R4 lbr always");
        run(8'hC8, 16'h4321, 8'h00, 0, "R4 lbr never");
        run(8'hC2, 16'h50FF, 8'h02, 0, "R4 lbr carry");
        run(8'hCB, 16'h5100, 8'h04, 0, "R4 lbr not q");
        run(8'hC4, 16'h5200, 8'hFF, 0, "R4 lbr ext src never");
        // R5 short skip
        run(8'hE0, 16'hFFFF, 8'h00, 0, "R5 short skip");
        // R6 long skip
        run(8'hD0, 16'h6000, 8'h00, 0, "R6 lskp always");
        run(8'hD8, 16'h6000, 8'h00, 0, "R6 lskp never");
        run(8'hD4, 16'h6100, 8'h80, 0, "R6 lskp ie set");
        run(8'hD4, 16'h6100, 8'h00, 0, "R6 lskp ie clear");
        run(8'hDC, 16'h6200, 8'h00, 0, "R6 lskp ie inverted never");
        run(8'hD3, 16'h6300, 8'h04, 0, "R6 lskp q");
        // R9 start while busy
        run(8'h31, 16'h7000, 8'h01, 1, "R9 poke in done cycle");
        run(8'hC1, 16'h7100, 8'h01, 1, "R9 poke during long");
        run(8'hD1, 16'h7200, 8'h00, 1, "R9 poke during long skip");

        // R2 unsupported opcode ignored
        prev = pc_o;
        dc = done_cnt;
        @(negedge clk);
        start_i = 1'b1; opcode_i = 8'h55; pc_i = 16'h4444;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        check(pc_o == prev, "R2 unsupported pc", pc_o, prev);
        check(done_cnt == dc, "R2 unsupported done", done_cnt, dc);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule